// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects up to 64 interrupt request lines, records a rising edge on each as a pending flag, and offers the CPU a single interrupt request together with the index and level of the most urgent source that may currently interrupt. Each source carries a mask bit and a 3-bit priority level. Level 0 is the most urgent and level 7 the least. An in-service register with one bit per level tracks nested handlers. A source may interrupt only when its level is strictly more urgent than every level now in service.

Software reaches the block over a byte-wide register bus with single-cycle writes and combinational reads. Each source has a control byte holding its pending flag, mask and level. The same mask bits can also be reached as packed bytes of eight sources each, so whole groups can be masked in one write. Writes to two command addresses acknowledge the presented interrupt and end the service of the most urgent active level.

A two-state machine drives the request output. In `ST_IDLE` the request is low, and the index and level outputs read zero. Transition `T_RAISE` moves to `ST_PRESENT` when an eligible source exists. In `ST_PRESENT`, transition `T_RETARGET` keeps the state and follows a changed winner. `T_TAKE` returns to `ST_IDLE` on an acknowledge write. `T_WITHDRAW` returns to `ST_IDLE` when no eligible source remains.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, every source is masked with level 7 (control byte reads 0x47), every packed mask byte reads 0xFF, and the in-service register reads 0.
- R2: A 0-to-1 transition on `src_irq[i]` sets the pending flag of source i at the next clock edge. An input that simply stays high does not set the flag again after it has been cleared.
- R3: The control byte of source i sits at address 2*i. Bits [2:0] hold its level, bit 6 its mask and bit 7 its pending flag; bits 5:3 read 0. Odd addresses in the control region read 0 and ignore writes. `irq_level` always equals the presented source's programmed level.
- R4: The packed mask byte at address 0x80 + (i >> 3) holds the mask of source i at bit (i & 7). That bit and control-byte bit 6 are one storage bit, so a write through either view is visible in the other. Writing 0xFF to a packed byte masks all eight of its sources.
- R5: A mask value of 1 keeps a source from being presented while its pending flag stays set. Once the source is unmasked, it is presented.
- R6: Writing a control byte with bit 7 = 0 clears that source's pending flag. Writing bit 7 = 1 does not set it. A rising edge in the same cycle wins over the clear.
- R7: Among eligible sources, the lowest level value wins. Ties go to the lowest source index.
- R8: `irq_req` rises two clock edges after the rising edge of an eligible input, or one edge after a register write makes a pending source eligible. While `irq_req` is 0, `irq_id` and `irq_level` are 0.
- R9: A write to address 0xA1 while `irq_req` is 1 clears the presented source's pending flag, sets the in-service bit of its level and drops `irq_req` at that edge. Such a write while `irq_req` is 0 changes nothing. In-service bits are set by nothing else.
- R10: A source is eligible only if no in-service bit is set at its own level or any more urgent level.
- R11: The in-service register reads at address 0xA0, bit n for level n. A write to address 0xA2 clears its lowest-numbered set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 64 | Interrupt request inputs, captured on rising edge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_id | output | 6 | Index of the presented source |
| irq_level | output | 3 | Level of the presented source |

## Verification
Every cycle, the checker confirms that a presented source was pending, unmasked and carried the reported level in the cycle it was chosen, and that no in-service bit blocked it. It also confirms that in-service bits appear only through an acknowledge, that an acknowledge drops the request and marks the presented level, and that each end-of-service write removes exactly one bit. What the properties cannot show is covered by the directed scenarios: the two views of the mask sharing a bit, tie-breaking by index, pending flags surviving a mask, edge-versus-level capture, and the exact cycle in which the request rises after nested service ends.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Request presentation states
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } req_state_t;

endpackage

// File: rtl/pic_edge_cap.sv
module pic_edge_cap #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    output logic [NUM_SRC-1:0] rise
);

    logic [NUM_SRC-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_irq;
    end

    // One-cycle pulse for each 0 -> 1 transition
    assign rise = src_irq & ~prev_q;

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    localparam int ID_W    = $clog2(NUM_SRC),
    localparam int NUM_LVL = 1 << LVL_W
) (
    input  logic [NUM_SRC-1:0]            pend,
    input  logic [NUM_SRC-1:0]            mask,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] prio,
    input  logic [NUM_LVL-1:0]            isr,
    output logic                          win_valid,
    output logic [ID_W-1:0]               win_id,
    output logic [LVL_W-1:0]              win_level
);

    logic [NUM_LVL-1:0] lvl_ok;
    logic [NUM_SRC-1:0] elig;

    // A level may interrupt only if it and every more urgent level are idle
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        assign lvl_ok[l] = ~|isr[l:0];
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign elig[s] = pend[s] & ~mask[s] & lvl_ok[prio[s]];
    end

    // Scan in index order; strict compare keeps the lowest index on ties
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_level = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!win_valid || prio[i] < win_level)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                win_level = prio[i];
            end
        end
    end

endmodule

// File: rtl/pic_req_fsm.sv
module pic_req_fsm
    import pic_pkg::*;
#(
    parameter int ID_W  = 6,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [ID_W-1:0]  win_id,
    input  logic [LVL_W-1:0] win_level,
    input  logic             ack_wr,
    output logic             irq_req,
    output logic [ID_W-1:0]  irq_id,
    output logic [LVL_W-1:0] irq_level,
    output logic             ack_take
);

    req_state_t       state_q, state_d;
    logic [ID_W-1:0]  id_q;
    logic [LVL_W-1:0] lvl_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: T_RAISE, T_RETARGET, T_TAKE, T_WITHDRAW
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_valid) state_d = ST_PRESENT;          // T_RAISE
            end
            ST_PRESENT: begin
                if (ack_wr)          state_d = ST_IDLE;      // T_TAKE
                else if (!win_valid) state_d = ST_IDLE;      // T_WITHDRAW
                else                 state_d = ST_PRESENT;   // T_RETARGET
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Presented source is sampled whenever the next state presents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q  <= '0;
            lvl_q <= '0;
        end else if (state_d == ST_PRESENT) begin
            id_q  <= win_id;
            lvl_q <= win_level;
        end
    end

    // Outputs
    always_comb begin
        irq_req   = 1'b0;
        irq_id    = '0;
        irq_level = '0;
        ack_take  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRESENT: begin
                irq_req   = 1'b1;
                irq_id    = id_q;
                irq_level = lvl_q;
                ack_take  = ack_wr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int ADDR_W  = 8,
    localparam int ID_W      = $clog2(NUM_SRC),
    localparam int NUM_LVL   = 1 << LVL_W,
    localparam int MASK_BYTES = NUM_SRC / 8,
    localparam int MB_W      = (MASK_BYTES > 1) ? $clog2(MASK_BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               irq_req,
    output logic [ID_W-1:0]    irq_id,
    output logic [LVL_W-1:0]   irq_level
);

    // Address map: control bytes at 2*i, packed masks right after, commands at +32
    localparam logic [ADDR_W-1:0] CTRL_END_A  = ADDR_W'(2 * NUM_SRC);
    localparam logic [ADDR_W-1:0] MASK_BASE_A = ADDR_W'(2 * NUM_SRC);
    localparam logic [ADDR_W-1:0] MASK_END_A  = ADDR_W'(2 * NUM_SRC + MASK_BYTES);
    localparam logic [ADDR_W-1:0] ISR_A       = ADDR_W'(2 * NUM_SRC + 32);
    localparam logic [ADDR_W-1:0] ACK_A       = ADDR_W'(2 * NUM_SRC + 33);
    localparam logic [ADDR_W-1:0] EOS_A       = ADDR_W'(2 * NUM_SRC + 34);

    logic [NUM_SRC-1:0]            pend_q;
    logic [NUM_SRC-1:0]            mask_q;
    logic [NUM_SRC-1:0][LVL_W-1:0] prio_q;
    logic [NUM_LVL-1:0]            isr_q;

    logic [NUM_SRC-1:0] rise;
    logic               ctrl_hit, mask_hit;
    logic [ID_W-1:0]    ctrl_idx;
    logic [MB_W-1:0]    mask_idx;
    logic               ack_wr, eos_wr, ack_take;
    logic               win_valid;
    logic [ID_W-1:0]    win_id;
    logic [LVL_W-1:0]   win_level;

    // Address decode
    assign ctrl_hit = (bus_addr < CTRL_END_A) && !bus_addr[0];
    assign ctrl_idx = bus_addr[ID_W:1];
    assign mask_hit = (bus_addr >= MASK_BASE_A) && (bus_addr < MASK_END_A);
    assign mask_idx = bus_addr[MB_W-1:0];   // mask base is a multiple of the byte count
    assign ack_wr   = bus_wr && (bus_addr == ACK_A);
    assign eos_wr   = bus_wr && (bus_addr == EOS_A);

    pic_edge_cap #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_irq (src_irq),
        .rise    (rise)
    );

    // Per-source state: pending flag, shared mask bit, level
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic wr_ctrl, wr_mask, acked;
        assign wr_ctrl = bus_wr && ctrl_hit && (ctrl_idx == ID_W'(s));
        assign wr_mask = bus_wr && mask_hit && (mask_idx == MB_W'(s / 8));
        assign acked   = ack_take && (irq_id == ID_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[s] <= 1'b0;
                mask_q[s] <= 1'b1;
                prio_q[s] <= '1;
            end else begin
                if (rise[s])
                    pend_q[s] <= 1'b1;
                else if (acked || (wr_ctrl && !bus_wdata[7]))
                    pend_q[s] <= 1'b0;

                if (wr_ctrl) begin
                    mask_q[s] <= bus_wdata[6];
                    prio_q[s] <= bus_wdata[LVL_W-1:0];
                end else if (wr_mask) begin
                    mask_q[s] <= bus_wdata[s % 8];
                end
            end
        end
    end

    // In-service levels: set on acknowledge, lowest set bit cleared on end-of-service
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            isr_q <= '0;
        else if (ack_take)
            isr_q <= isr_q | (NUM_LVL'(1) << irq_level);
        else if (eos_wr)
            isr_q <= isr_q & (isr_q - NUM_LVL'(1));
    end

    pic_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
        .pend      (pend_q),
        .mask      (mask_q),
        .prio      (prio_q),
        .isr       (isr_q),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_level (win_level)
    );

    pic_req_fsm #(.ID_W(ID_W), .LVL_W(LVL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_level (win_level),
        .ack_wr    (ack_wr),
        .irq_req   (irq_req),
        .irq_id    (irq_id),
        .irq_level (irq_level),
        .ack_take  (ack_take)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) begin
            bus_rdata    = 8'(prio_q[ctrl_idx]);
            bus_rdata[6] = mask_q[ctrl_idx];
            bus_rdata[7] = pend_q[ctrl_idx];
        end else if (mask_hit) begin
            bus_rdata = mask_q[{mask_idx, 3'b000} +: 8];
        end else if (bus_addr == ISR_A) begin
            bus_rdata = 8'(isr_q);
        end
    end

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    localparam int ID_W    = $clog2(NUM_SRC),
    localparam int NUM_LVL = 1 << LVL_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          irq_req,
    input logic [ID_W-1:0]               irq_id,
    input logic [LVL_W-1:0]              irq_level,
    input logic [NUM_SRC-1:0]            pend_q,
    input logic [NUM_SRC-1:0]            mask_q,
    input logic [NUM_SRC-1:0][LVL_W-1:0] prio_q,
    input logic [NUM_LVL-1:0]            isr_q,
    input logic                          ack_take,
    input logic                          eos_wr
);

    // Previous-cycle copies: the presented source was chosen from these
    logic [NUM_SRC-1:0]            pend_p, mask_p;
    logic [NUM_SRC-1:0][LVL_W-1:0] prio_p;
    logic [NUM_LVL-1:0]            isr_p;
    logic [LVL_W-1:0]              lvl_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_p <= '0;
            mask_p <= '1;
            prio_p <= '1;
            isr_p  <= '0;
            lvl_p  <= '0;
        end else begin
            pend_p <= pend_q;
            mask_p <= mask_q;
            prio_p <= prio_q;
            isr_p  <= isr_q;
            lvl_p  <= irq_level;
        end
    end

    AST_REQ_UNMASKED_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_p[irq_id] && !mask_p[irq_id])); // R5

    AST_REQ_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (prio_p[irq_id] == irq_level)); // R3

    AST_REQ_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((isr_p & ((NUM_LVL'(2) << irq_level) - NUM_LVL'(1))) == '0)); // R10

    AST_IDLE_ZERO_ID: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_id == '0 && irq_level == '0)); // R8

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> !irq_req); // R9

    AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> isr_q[lvl_p]); // R9

    AST_ISR_SET_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_take |=> ((isr_q & ~$past(isr_q)) == '0)); // R9

    AST_EOS_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_wr && isr_q != '0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R11

endmodule

bind prio_irq_ctrl pic_checker #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_id    (irq_id),
    .irq_level (irq_level),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .prio_q    (prio_q),
    .isr_q     (isr_q),
    .ack_take  (ack_take),
    .eos_wr    (eos_wr)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;

    localparam logic [7:0] MASKB = 8'h80;
    localparam logic [7:0] ISRA  = 8'hA0;
    localparam logic [7:0] ACKA  = 8'hA1;
    localparam logic [7:0] EOSA  = 8'hA2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_irq = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_req;
    logic [5:0]  irq_id;
    logic [2:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_id    (irq_id),
        .irq_level (irq_level)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_irq = '0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int s);
        @(negedge clk); src_irq[s] = 1'b1;
        @(negedge clk); src_irq[s] = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R1", "irq_req", int'(irq_req), 0);
        chk("R1", "irq_level", int'(irq_level), 0);
        bus_read(8'd10, d); chk("R1", "ctrl byte src5", int'(d), 'h47);
        bus_read(MASKB + 8'd7, d); chk("R1", "mask byte 7", int'(d), 'hFF);
        bus_read(ISRA, d); chk("R1", "in-service", int'(d), 0);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        do_reset();
        bus_write(8'd6, 8'h3A);
        bus_read(8'd6, d); chk("R3", "ctrl src3 level, bits 5:3 zero", int'(d), 'h02);
        bus_write(8'd7, 8'hFF);
        bus_read(8'd7, d); chk("R3", "odd address reads 0", int'(d), 0);
        bus_read(8'd6, d); chk("R3", "odd write ignored", int'(d), 'h02);
    endtask

    task automatic t_mask_views();
        logic [7:0] d;
        do_reset();
        bus_write(8'd18, 8'h01);
        bus_read(MASKB + 8'd1, d); chk("R4", "packed byte shows src9 unmasked", int'(d), 'hFD);
        bus_write(MASKB + 8'd1, 8'h00);
        bus_read(8'd30, d); chk("R4", "ctrl src15 after packed clear", int'(d), 'h07);
        bus_write(MASKB + 8'd1, 8'hFF);
        bus_read(8'd18, d); chk("R4", "ctrl src9 after 0xFF", int'(d), 'h41);
        bus_read(8'd30, d); chk("R4", "ctrl src15 after 0xFF", int'(d), 'h47);
    endtask

    task automatic t_mask_pending();
        logic [7:0] d;
        do_reset();
        pulse(4);
        repeat (2) @(negedge clk);
        chk("R5", "masked source not requested", int'(irq_req), 0);
        bus_read(8'd8, d); chk("R5", "masked source stays pending", int'(d), 'hC7);
        bus_write(MASKB, 8'hEF);
        chk("R8", "request one edge after unmask, not yet", int'(irq_req), 0);
        @(negedge clk);
        chk("R5", "request after unmask", int'(irq_req), 1);
        chk("R5", "id after unmask", int'(irq_id), 4);
        chk("R3", "level after unmask", int'(irq_level), 7);
    endtask

    task automatic t_clear_pending();
        logic [7:0] d;
        do_reset();
        @(negedge clk); src_irq[10] = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(8'd20, d); chk("R2", "edge captured", int'(d), 'hC7);
        bus_write(8'd20, 8'h47);
        bus_read(8'd20, d); chk("R6", "bit7=0 clears", int'(d), 'h47);
        repeat (3) @(negedge clk);
        bus_read(8'd20, d); chk("R2", "held level not recaptured", int'(d), 'h47);
        bus_write(8'd20, 8'hC7);
        bus_read(8'd20, d); chk("R6", "bit7=1 does not set", int'(d), 'h47);
        @(negedge clk); src_irq[10] = 1'b0;
        pulse(10);
        bus_read(8'd20, d); chk("R2", "new edge captured", int'(d), 'hC7);
    endtask

    task automatic t_arbitration();
        do_reset();
        bus_write(8'd40, 8'h03);
        bus_write(8'd14, 8'h03);
        bus_write(8'd100, 8'h01);
        pulse(20);
        chk("R8", "no request one edge after capture", int'(irq_req), 0);
        @(negedge clk);
        chk("R8", "request two edges after input edge", int'(irq_req), 1);
        chk("R7", "single source id", int'(irq_id), 20);
        chk("R7", "single source level", int'(irq_level), 3);
        pulse(7);
        @(negedge clk);
        chk("R7", "tie goes to lower index", int'(irq_id), 7);
        pulse(50);
        @(negedge clk);
        chk("R7", "more urgent level wins", int'(irq_id), 50);
        chk("R7", "winning level", int'(irq_level), 1);
    endtask

    task automatic t_nesting();
        logic [7:0] d;
        do_reset();
        bus_write(8'd4, 8'h04);
        bus_write(8'd6, 8'h04);
        bus_write(8'd2, 8'h02);
        bus_write(8'd0, 8'h06);
        pulse(2);
        @(negedge clk);
        chk("R9", "presented before ack", int'(irq_id), 2);
        bus_write(ACKA, 8'h00);
        chk("R9", "ack drops request", int'(irq_req), 0);
        chk("R8", "id zero while idle", int'(irq_id), 0);
        bus_read(ISRA, d); chk("R9", "ack sets level 4 in service", int'(d), 'h10);
        bus_read(8'd4, d); chk("R9", "ack clears pending", int'(d), 'h04);
        pulse(3);
        pulse(0);
        repeat (2) @(negedge clk);
        chk("R10", "equal and lower levels blocked", int'(irq_req), 0);
        pulse(1);
        @(negedge clk);
        chk("R10", "more urgent level nests", int'(irq_id), 1);
        bus_write(ACKA, 8'h00);
        bus_read(ISRA, d); chk("R9", "nested in-service", int'(d), 'h14);
        bus_write(EOSA, 8'h00);
        bus_read(ISRA, d); chk("R11", "end clears most urgent level", int'(d), 'h10);
        repeat (2) @(negedge clk);
        chk("R10", "still blocked by level 4", int'(irq_req), 0);
        bus_write(EOSA, 8'h00);
        chk("R8", "one edge after end, not yet", int'(irq_req), 0);
        @(negedge clk);
        chk("R10", "request resumes", int'(irq_req), 1);
        chk("R7", "level 4 beats level 6", int'(irq_id), 3);
        chk("R3", "resumed level", int'(irq_level), 4);
        bus_read(8'd0, d); chk("R5", "blocked source still pending", int'(d), 'h86);
    endtask

    task automatic t_ack_idle();
        logic [7:0] d;
        do_reset();
        bus_write(ACKA, 8'h00);
        bus_read(ISRA, d); chk("R9", "ack while idle ignored", int'(d), 0);
        chk("R9", "no request after idle ack", int'(irq_req), 0);
        bus_write(EOSA, 8'h00);
        bus_read(ISRA, d); chk("R11", "end with nothing in service", int'(d), 0);
    endtask

    initial begin
        t_reset();
        t_layout();
        t_mask_views();
        t_mask_pending();
        t_clear_pending();
        t_arbitration();
        t_nesting();
        t_ack_idle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run hung actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule